// File: doc/BRIEF.md
# Floating-point mantissa rounding stage

This block takes an unpacked floating-point mantissa that still carries two extra low-order bits below its least significant bit, plus a separate sticky bit, the operand sign and a two-bit rounding-direction code. It drops the two extra bits and rounds the remaining mantissa in the selected direction. It reports whether the value was inexact and whether an increment was applied.

The result is one bit wider than the kept mantissa, so a carry out of the top bit survives. An all-ones mantissa that rounds up therefore comes out as a single one in the top position, which represents 2.0. A later packing stage uses the rounded-up flag and that top bit to renormalise and to bump the exponent. The exponent itself, packing and trapping are outside this block.

Operands are accepted on a valid strobe. The result appears, registered, on the clock edge that samples the strobe, and it is held until the next strobe.

Top module: `mant_round`

## Requirements
- R1: `out_valid` is 0 after reset. It is 1 in exactly the cycle after each cycle in which `in_valid` is 1, so back-to-back operands produce back-to-back results.
- R2: When `in_mant[1]` (guard), `in_mant[0]` (round) and `in_sticky` are all 0, the result is exact in every mode. `out_inexact` is 0, `out_rounded_up` is 0, and `out_mant` equals `in_mant` shifted right by two with a 0 top bit.
- R3: When any of guard, round or sticky is 1, `out_inexact` is 1, whatever the mode.
- R4: Mode code 2'b00 is round to nearest. An increment happens only if guard is 1, and then only if round, sticky or the kept LSB (`in_mant[2]`) is 1.
- R5: In mode 2'b00 a tie is guard 1 with round 0 and sticky 0. A tie increments only when `in_mant[2]` is 1 (ties go to even).
- R6: Mode code 2'b01 is round toward zero and never increments.
- R7: Mode code 2'b10 is round toward minus infinity. It increments an inexact value only when `in_sign` is 1.
- R8: Mode code 2'b11 is round toward plus infinity. It increments an inexact value only when `in_sign` is 0.
- R9: The increment adds one at the LSB with carry through the whole kept width. An all-ones kept mantissa that rounds up gives `out_mant` with only its top bit (bit MANT_W) set.
- R10: `out_rounded_up` is 1 exactly when `out_mant` equals the shifted input plus one. Otherwise `out_mant` equals the shifted input and `out_rounded_up` is 0.
- R11: While `in_valid` is 0, `out_mant`, `out_inexact` and `out_rounded_up` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_mant | input | MANT_W+2 | Mantissa with guard in bit 1 and round in bit 0 |
| in_sticky | input | 1 | Sticky bit, the OR of all bits below round |
| in_sign | input | 1 | Operand sign, 1 is negative |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_mant | output | MANT_W+1 | Rounded mantissa, with the carry kept in the top bit |
| out_inexact | output | 1 | Guard, round or sticky was set |
| out_rounded_up | output | 1 | An increment was applied |

## Verification
Exact operands are sent in every mode, with both signs, so that each mode is shown never to increment when nothing was discarded. Round to nearest is tried with:
- guard alone on even and odd kept mantissas, which separates a tie going to even from one that always rounds up;
- guard with round or sticky, which shows that a tie-breaker forces the increment;
- round and sticky without guard, which shows that such inputs never round up.

The directed modes get inexact operands of both signs, which exposes a swapped sign test. An all-ones mantissa that rounds up checks the full carry into the top bit. A stream of random operands in all modes, sent back to back and with gaps, checks the pipeline timing and that the outputs hold between strobes.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  // Rounding direction codes as seen on the in_mode port.
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_NEG_INF = 2'b10,
    RM_POS_INF = 2'b11
  } rnd_mode_e;

  // Number of extra low-order bits: guard and round.
  localparam int GR_W = 2;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      inexact_o,
  output logic      bump_o
);
  logic lost;

  always_comb begin
    lost = guard_i | round_i | sticky_i;
    case (mode_i)
      RM_ZERO:    bump_o = 1'b0;
      RM_NEG_INF: bump_o = lost & sign_i;
      RM_POS_INF: bump_o = lost & ~sign_i;
      default:    bump_o = guard_i & (round_i | sticky_i | lsb_i);
    endcase
    inexact_o = lost;
  end

  // R2: nothing was discarded, so no mode may increment.
  always_comb begin
    assert_exact_no_bump_R2: assert (!(bump_o && !inexact_o))
      else $error("increment on an exact operand");
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int  WIDTH    = 64,
  parameter bit  FAST_ADD = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   sum_o
);
  generate
    if (FAST_ADD) begin : g_fast
      // The tool picks the adder structure.
      assign sum_o = {1'b0, a_i} + {{WIDTH{1'b0}}, cin_i};
    end else begin : g_ripple
      // Explicit ripple chain of half adders.
      logic [WIDTH:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]    = a_i[i] ^ carry[i];
        assign carry[i+1]  = a_i[i] & carry[i];
      end
      assign sum_o[WIDTH] = carry[WIDTH];
    end
  endgenerate
endmodule

// File: rtl/mant_round.sv
module mant_round
  import rnd_pkg::*;
#(
  parameter int MANT_W   = 64,
  parameter bit FAST_ADD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W+1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [MANT_W:0]   out_mant,
  output logic              out_inexact,
  output logic              out_rounded_up
);
  localparam int IN_W  = MANT_W + GR_W;
  localparam int OUT_W = MANT_W + 1;

  logic [MANT_W-1:0] kept;
  logic              inexact_c;
  logic              bump_c;
  logic [OUT_W-1:0]  sum_c;

  logic              valid_d, valid_q;
  logic [OUT_W-1:0]  mant_d, mant_q;
  logic              inex_d, inex_q;
  logic              up_d, up_q;

  assign kept = in_mant[IN_W-1:GR_W];

  rnd_decide u_decide (
    .guard_i   (in_mant[1]),
    .round_i   (in_mant[0]),
    .sticky_i  (in_sticky),
    .lsb_i     (in_mant[GR_W]),
    .sign_i    (in_sign),
    .mode_i    (rnd_mode_e'(in_mode)),
    .inexact_o (inexact_c),
    .bump_o    (bump_c)
  );

  rnd_incr #(.WIDTH(MANT_W), .FAST_ADD(FAST_ADD)) u_incr (
    .a_i   (kept),
    .cin_i (bump_c),
    .sum_o (sum_c)
  );

  // Next-state logic with the clock enable written out.
  always_comb begin
    valid_d = in_valid;
    mant_d  = mant_q;
    inex_d  = inex_q;
    up_d    = up_q;
    if (in_valid) begin
      mant_d = sum_c;
      inex_d = inexact_c;
      up_d   = bump_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mant_q  <= '0;
      inex_q  <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mant_q  <= mant_d;
      inex_q  <= inex_d;
      up_q    <= up_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_mant       = mant_q;
  assign out_inexact    = inex_q;
  assign out_rounded_up = up_q;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mant[1] || in_mant[0] || in_sticky)) |=> out_inexact);
  assert_nearest_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_rounded_up);
  assert_tie_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00 && in_mant[1:0] == 2'b10 && !in_sticky && !in_mant[2])
    |=> !out_rounded_up);
  assert_toward_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=> !out_rounded_up);
  assert_neg_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10 && !in_sign) |=> !out_rounded_up);
  assert_pos_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11 && in_sign) |=> !out_rounded_up);
  assert_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_mant == ({1'b0, $past(kept)} + {{MANT_W{1'b0}}, out_rounded_up})));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mant) && $stable(out_inexact) && $stable(out_rounded_up)));
endmodule

// File: tb/sim_mant_round.sv
`timescale 1ns/1ps
module sim_mant_round;
  localparam int MW = 64;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [MW+1:0] in_mant;
  logic          in_sticky;
  logic          in_sign;
  logic [1:0]    in_mode;
  logic          out_valid;
  logic [MW:0]   out_mant;
  logic          out_inexact;
  logic          out_rounded_up;

  int checks;
  int errors;

  logic [MW:0] q_mant[$];
  logic        q_inex[$];
  logic        q_up[$];
  string       q_tag[$];
  logic [MW:0] last_mant;
  logic        last_inex;
  logic        last_up;

  mant_round #(.MANT_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
    .out_valid(out_valid), .out_mant(out_mant), .out_inexact(out_inexact),
    .out_rounded_up(out_rounded_up)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected result from the requirements.
  task automatic model(input logic [MW+1:0] m, input logic s, input logic sg,
                       input logic [1:0] md, output logic [MW:0] r,
                       output logic ix, output logic up);
    logic g, rb, lsb;
    g = m[1]; rb = m[0]; lsb = m[2];
    ix = g | rb | s;
    case (md)
      2'b00:   up = g & (rb | s | lsb);
      2'b01:   up = 1'b0;
      2'b10:   up = ix & sg;
      default: up = ix & ~sg;
    endcase
    r = {1'b0, m[MW+1:2]} + {{MW{1'b0}}, up};
  endtask

  task automatic check(input string tag, input logic ok, input logic [MW:0] act,
                       input logic [MW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [MW+1:0] m, input logic s, input logic sg,
                      input logic [1:0] md, input string tag);
    logic [MW:0] r;
    logic ix, up;
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_sticky = s; in_sign = sg; in_mode = md;
    model(m, s, sg, md, r, ix, up);
    q_mant.push_back(r); q_inex.push_back(ix); q_up.push_back(up); q_tag.push_back(tag);
    last_mant = r; last_inex = ix; last_up = up;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item for each valid result.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_mant.size() == 0) begin
        check("R1 unexpected out_valid", 1'b0, out_mant, '0);
      end else begin
        logic [MW:0] em;
        logic ei, eu;
        string t;
        em = q_mant.pop_front(); ei = q_inex.pop_front();
        eu = q_up.pop_front(); t = q_tag.pop_front();
        check({t, " mant"}, out_mant == em, out_mant, em);
        check({t, " inexact"}, out_inexact == ei, {{MW{1'b0}}, out_inexact}, {{MW{1'b0}}, ei});
        check({t, " rounded_up R10"}, out_rounded_up == eu,
              {{MW{1'b0}}, out_rounded_up}, {{MW{1'b0}}, eu});
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL R1 watchdog actual=%0d expected=<20000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_mant = '0; in_sticky = 1'b0;
    in_sign = 1'b0; in_mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", out_valid == 1'b0, {{MW{1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    idle(2);

    // R2 exact operands, every mode and both signs
    send({64'h0000_0000_1234_5678, 2'b00}, 1'b0, 1'b0, 2'b00, "R2 exact nearest");
    send({64'hFFFF_FFFF_FFFF_FFFF, 2'b00}, 1'b0, 1'b1, 2'b10, "R2 exact neg-inf");
    send({64'h8000_0000_0000_0001, 2'b00}, 1'b0, 1'b0, 2'b11, "R2 exact pos-inf");
    send({64'h0F0F_0F0F_0F0F_0F0F, 2'b00}, 1'b0, 1'b1, 2'b01, "R2 exact zero");
    idle(1);
    // R4 and R5 nearest
    send({64'h0000_0000_0000_0010, 2'b10}, 1'b0, 1'b0, 2'b00, "R5 tie even");
    send({64'h0000_0000_0000_0011, 2'b10}, 1'b0, 1'b1, 2'b00, "R5 tie odd");
    send({64'h0000_0000_0000_0010, 2'b11}, 1'b0, 1'b0, 2'b00, "R4 guard+round");
    send({64'h0000_0000_0000_0010, 2'b10}, 1'b1, 1'b0, 2'b00, "R4 guard+sticky");
    send({64'h0000_0000_0000_0011, 2'b01}, 1'b1, 1'b0, 2'b00, "R4 no guard R3");
    // R6 toward zero
    send({64'h0000_0000_0000_0011, 2'b11}, 1'b1, 1'b0, 2'b01, "R6 zero pos");
    send({64'h0000_0000_0000_0011, 2'b11}, 1'b1, 1'b1, 2'b01, "R6 zero neg");
    // R7 and R8 directed modes
    send({64'h0000_0000_0000_0100, 2'b01}, 1'b0, 1'b1, 2'b10, "R7 neg-inf neg");
    send({64'h0000_0000_0000_0100, 2'b00}, 1'b1, 1'b0, 2'b10, "R7 neg-inf pos");
    send({64'h0000_0000_0000_0100, 2'b00}, 1'b1, 1'b0, 2'b11, "R8 pos-inf pos");
    send({64'h0000_0000_0000_0100, 2'b01}, 1'b0, 1'b1, 2'b11, "R8 pos-inf neg");
    // R9 carry out of the top bit
    send({64'hFFFF_FFFF_FFFF_FFFF, 2'b11}, 1'b0, 1'b0, 2'b00, "R9 carry nearest");
    send({64'hFFFF_FFFF_FFFF_FFFF, 2'b01}, 1'b0, 1'b1, 2'b10, "R9 carry neg-inf");
    idle(2);
    // R11 hold while idle
    idle(3);
    check("R11 hold mant", out_mant == last_mant, out_mant, last_mant);
    check("R11 hold flags", {out_inexact, out_rounded_up} == {last_inex, last_up},
          {{(MW-1){1'b0}}, out_inexact, out_rounded_up}, {{(MW-1){1'b0}}, last_inex, last_up});
    check("R1 idle out_valid", out_valid == 1'b0, {{MW{1'b0}}, out_valid}, '0);

    // Random operands, back to back and with gaps
    for (int i = 0; i < 60; i++) begin
      logic [MW+1:0] m;
      logic [1:0] md;
      m = {$urandom, $urandom, $urandom};
      md = 2'($urandom);
      case (md)
        2'b00: send(m, 1'($urandom), 1'($urandom), md, "R4 random nearest");
        2'b01: send(m, 1'($urandom), 1'($urandom), md, "R6 random zero");
        2'b10: send(m, 1'($urandom), 1'($urandom), md, "R7 random neg-inf");
        default: send(m, 1'($urandom), 1'($urandom), md, "R8 random pos-inf");
      endcase
      if (($urandom % 4) == 0) idle(1);
    end
    idle(3);
    check("R1 all results seen", q_mant.size() == 0,
          (MW+1)'(q_mant.size()), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule